// File: doc/BRIEF.md
# Trigger Latency Pipeline Controller

This block holds recent hit history for a detector front end and keeps the events that a trigger selects. Every clock, a 128-bit hit word is written into a 256-entry circular pipeline at a write pointer that advances by one per clock. A second pointer, the trigger pointer, trails the write pointer by a programmable latency. When the trigger input is high, the word under the trigger pointer is copied into a 32-entry event buffer. The buffer behaves as a FIFO, and the pipeline address of each event is stored beside it in a single-error-correcting code.

After reset, and again whenever the latency setting changes, the write pointer restarts at zero. The trigger pointer is started only once the write pointer has moved the programmed distance ahead. From then on a separation check compares the two pointers on every clock against the latency setting. An occupancy counter drives the count, empty and full outputs that a downstream readout uses to fetch events.

Top module: `trig_latency_ctrl`

## Requirements
- R1: With a latency setting L (1 to 255, and 0 meaning 256), a trigger sampled at clock edge t captures the hit word that was sampled at edge t-L.
- R2: After reset or a latency change, the first L clock edges fill the pipeline, and triggers sampled on those edges are ignored. The first trigger that is accepted, at edge L+1, captures pipeline address 0. Following triggers capture the next addresses in order, modulo 256.
- R3: The event's pipeline address is stored as a 12-bit Hamming code: parity bits at code positions 1, 2, 4 and 8 (even parity), and the address bits from LSB up at positions 3, 5, 6, 7, 9, 10, 11 and 12. On read, any single flipped bit is corrected, and evt_addr presents the original address.
- R4: err_lat is registered. It is high in the cycle after an edge at which the trigger pointer is running and the pointer separation differs from lat_cfg. A latency change therefore raises it for exactly one cycle, and the restart clears it. In steady operation it stays low.
- R5: Events leave the buffer in trigger order. evt_data and evt_addr always show the oldest event, and evt_pop removes it.
- R6: A trigger that arrives while 32 events are held is dropped and sets err_full. err_full stays set until reset.
- R7: evt_cnt gives the occupancy (0 to 32), with evt_empty at 0 and evt_full at 32. An accepted trigger and a pop on the same edge leave the count unchanged.
- R8: A pop while the buffer is empty has no effect on count, flags or later event order.
- R9: A trigger is accepted on every clock edge if presented, which is more than the one-in-three-clocks peak rate.
- R10: Synchronous active-low reset empties the buffer and clears err_lat and err_full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lat_cfg | input | 8 | Trigger latency in clocks; 0 selects 256 |
| trig | input | 1 | Trigger request, one per high cycle |
| hit_word | input | 128 | Hit word written into the pipeline every clock |
| evt_pop | input | 1 | Remove the oldest buffered event |
| evt_data | output | 128 | Hit word of the oldest event |
| evt_addr | output | 8 | Corrected pipeline address of the oldest event |
| evt_cnt | output | 6 | Number of buffered events |
| evt_empty | output | 1 | Buffer holds no event |
| evt_full | output | 1 | Buffer holds 32 events |
| err_lat | output | 1 | Pointer separation mismatch seen on the previous edge |
| err_full | output | 1 | Sticky: a trigger was dropped because the buffer was full |

## Verification
The hardest cases to reach are the edges of the start-up window. One is the trigger at edge L, which must be dropped, followed by the trigger at edge L+1, which must capture address 0. The other is the 256-clock latency, where the two pointers sit on the same address. The bench sweeps the latency through small, middle and extreme values, changing lat_cfg while the pointers run, and places a trigger exactly on each boundary edge, computed from the restart edge. The one-cycle latency error appears only on such a change, and the corrected address path is swept separately over every address with every single-bit flip.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
   localparam int PTR_W  = 8;
   localparam int PAR_W  = 4;
   localparam int CODE_W = PTR_W + PAR_W;

   // Single-error-correcting code: parity at power-of-two positions (1-based).
   function automatic logic [CODE_W-1:0] ham_enc(input logic [PTR_W-1:0] d);
      logic [CODE_W-1:0] c;
      int                k;
      logic              x;
      c = '0;
      k = 0;
      for (int p = 1; p <= CODE_W; p++) begin
         if ((p & (p - 1)) != 0) begin
            c[p-1] = d[k];
            k++;
         end
      end
      for (int i = 0; i < PAR_W; i++) begin
         x = 1'b0;
         for (int p = 1; p <= CODE_W; p++) begin
            if (((p >> i) & 1) == 1 && p != (1 << i)) x = x ^ c[p-1];
         end
         c[(1 << i) - 1] = x;
      end
      return c;
   endfunction

   function automatic logic [PTR_W-1:0] ham_dec(input logic [CODE_W-1:0] code);
      logic [CODE_W-1:0] c;
      logic [PAR_W-1:0]  s;
      logic [PTR_W-1:0]  d;
      int                k;
      c = code;
      s = '0;
      for (int p = 1; p <= CODE_W; p++) begin
         if (c[p-1]) s = s ^ PAR_W'(p);
      end
      if (s != '0 && int'(s) <= CODE_W) c[int'(s) - 1] = ~c[int'(s) - 1];
      d = '0;
      k = 0;
      for (int p = 1; p <= CODE_W; p++) begin
         if ((p & (p - 1)) != 0) begin
            d[k] = c[p-1];
            k++;
         end
      end
      return d;
   endfunction
endpackage

// File: rtl/lpc_ptr_ctrl.sv
module lpc_ptr_ctrl
   import lpc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PTR_W-1:0] lat_cfg,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] trg_ptr,
   output logic             trg_run,
   output logic             err_lat
);
   logic [PTR_W-1:0] lat_q;
   logic             restart;

   assign restart = (lat_cfg != lat_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_q   <= lat_cfg;
         wr_ptr  <= '0;
         trg_ptr <= '0;
         trg_run <= 1'b0;
         err_lat <= 1'b0;
      end else begin
         err_lat <= trg_run && (PTR_W'(wr_ptr - trg_ptr) != lat_cfg);
         if (restart) begin
            lat_q   <= lat_cfg;
            wr_ptr  <= '0;
            trg_ptr <= '0;
            trg_run <= 1'b0;
         end else begin
            wr_ptr <= wr_ptr + 1'b1;
            if (trg_run) trg_ptr <= trg_ptr + 1'b1;
            else if (wr_ptr == PTR_W'(lat_q - 1'b1)) trg_run <= 1'b1;
         end
      end
   end

   p_wr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> wr_ptr == PTR_W'($past(wr_ptr) + 1'b1));
   p_start_sep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trg_run) |-> (trg_ptr == '0 && wr_ptr == lat_q));
   p_err_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      err_lat |=> !err_lat);
endmodule

// File: rtl/lpc_pipe_ram.sv
module lpc_pipe_ram #(
   parameter int  WORD_W = 128,
   parameter int  DEPTH  = 256,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) mem[wr_addr] <= wr_data;

   // Read returns the stored word; a same-edge write lands after the read.
   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/lpc_event_fifo.sv
module lpc_event_fifo
   import lpc_pkg::*;
#(
   parameter int  DATA_W = 128,
   parameter int  DEPTH  = 32,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic [PTR_W-1:0]  push_addr,
   input  logic              pop,
   output logic [DATA_W-1:0] head_data,
   output logic [PTR_W-1:0]  head_addr,
   output logic [CNT_W-1:0]  cnt,
   output logic              empty,
   output logic              full,
   output logic              err_full
);
   initial begin : g_depth_chk
      assert (DEPTH == (1 << IDX_W)) else $error("event buffer depth must be a power of two");
   end

   logic [DATA_W-1:0] dat_q  [DEPTH];
   logic [CODE_W-1:0] code_q [DEPTH];
   logic [IDX_W-1:0]  wp, rp;
   logic              push_ok, pop_ok;

   assign full    = (cnt == CNT_W'(DEPTH));
   assign empty   = (cnt == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp       <= '0;
         rp       <= '0;
         cnt      <= '0;
         err_full <= 1'b0;
      end else begin
         if (push_ok) wp <= wp + 1'b1;
         if (pop_ok)  rp <= rp + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
         if (push && full) err_full <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) begin
         dat_q[wp]  <= push_data;
         code_q[wp] <= ham_enc(push_addr);
      end
   end

   assign head_data = dat_q[rp];
   assign head_addr = ham_dec(code_q[rp]);

   p_drop_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (full && err_full));
   p_sticky_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_full |=> err_full);
   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));
   p_push_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !full && !empty) |=> $stable(cnt));
   p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> empty);
endmodule

// File: rtl/trig_latency_ctrl.sv
module trig_latency_ctrl
   import lpc_pkg::*;
#(
   parameter int  WORD_W     = 128,
   parameter int  PIPE_DEPTH = 256,
   parameter int  BUF_DEPTH  = 32,
   localparam int CNT_W      = $clog2(BUF_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PTR_W-1:0]  lat_cfg,
   input  logic              trig,
   input  logic [WORD_W-1:0] hit_word,
   input  logic              evt_pop,
   output logic [WORD_W-1:0] evt_data,
   output logic [PTR_W-1:0]  evt_addr,
   output logic [CNT_W-1:0]  evt_cnt,
   output logic              evt_empty,
   output logic              evt_full,
   output logic              err_lat,
   output logic              err_full
);
   initial begin : g_param_chk
      assert (PIPE_DEPTH == (1 << PTR_W)) else $error("pipeline depth must match pointer width");
      assert (BUF_DEPTH >= 2) else $error("event buffer too shallow");
   end

   logic [PTR_W-1:0]  wr_ptr, trg_ptr;
   logic              trg_run;
   logic [WORD_W-1:0] pipe_rd;

   lpc_ptr_ctrl u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .lat_cfg (lat_cfg),
      .wr_ptr  (wr_ptr),
      .trg_ptr (trg_ptr),
      .trg_run (trg_run),
      .err_lat (err_lat)
   );

   lpc_pipe_ram #(.WORD_W(WORD_W), .DEPTH(PIPE_DEPTH)) u_pipe (
      .clk     (clk),
      .wr_addr (wr_ptr),
      .wr_data (hit_word),
      .rd_addr (trg_ptr),
      .rd_data (pipe_rd)
   );

   lpc_event_fifo #(.DATA_W(WORD_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (trig && trg_run),
      .push_data (pipe_rd),
      .push_addr (trg_ptr),
      .pop       (evt_pop),
      .head_data (evt_data),
      .head_addr (evt_addr),
      .cnt       (evt_cnt),
      .empty     (evt_empty),
      .full      (evt_full),
      .err_full  (err_full)
   );

   p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !trg_run && !evt_pop) |=> $stable(evt_cnt));
endmodule

// File: tb/trig_latency_ctrl_bench.sv
module trig_latency_ctrl_bench;
   import lpc_pkg::*;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   lat_cfg = 8'd5;
   logic         trig = 1'b0;
   logic [127:0] hit_word = '0;
   logic         evt_pop = 1'b0;
   logic [127:0] evt_data;
   logic [7:0]   evt_addr;
   logic [5:0]   evt_cnt;
   logic         evt_empty, evt_full, err_lat, err_full;

   int total = 0, bad = 0, edge_no = 0, rs = 0, cur_leff = 5;
   bit exp_full = 1'b0, done = 1'b0;
   logic [127:0] exp_d[$];
   logic [7:0]   exp_a[$];

   always #2 clk = ~clk;
   always @(posedge clk) edge_no <= edge_no + 1;

   function automatic logic [127:0] pat(input int e);
      return {32'(e) ^ 32'hC3A50000, ~32'(e), 32'(e * 7 + 1), 32'(e) + 32'h1000_0000};
   endfunction

   always @(negedge clk) hit_word <= pat(edge_no + 1);

   trig_latency_ctrl u_trig_latency_ctrl (
      .clk(clk), .rst_n(rst_n), .lat_cfg(lat_cfg), .trig(trig), .hit_word(hit_word),
      .evt_pop(evt_pop), .evt_data(evt_data), .evt_addr(evt_addr), .evt_cnt(evt_cnt),
      .evt_empty(evt_empty), .evt_full(evt_full), .err_lat(err_lat), .err_full(err_full)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] got, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wait_until(input int t);
      while (edge_no + 1 < t) @(negedge clk);
   endtask

   // R1 R2 R6 R9: one trigger on the next edge, modelled from the restart edge
   task automatic fire();
      int t;
      t = edge_no + 1;
      trig = 1'b1;
      if (t >= rs + cur_leff + 1) begin
         if (exp_d.size() < 32) begin
            exp_d.push_back(pat(t - cur_leff));
            exp_a.push_back(8'(t - cur_leff - rs - 1));
         end else exp_full = 1'b1;
      end
      @(negedge clk);
      trig = 1'b0;
      chk(err_full == exp_full, "R6 err_full", 128'(err_full), 128'(exp_full));
   endtask

   task automatic pop_check();
      logic [127:0] ed;
      logic [7:0]   ea;
      ed = exp_d.pop_front();
      ea = exp_a.pop_front();
      chk(evt_data == ed, "R1/R5 event data", evt_data, ed);
      chk(evt_addr == ea, "R2/R3 event address", 128'(evt_addr), 128'(ea));
      evt_pop = 1'b1;
      @(negedge clk);
      evt_pop = 1'b0;
   endtask

   task automatic fire_pop();
      int t;
      int n;
      t = edge_no + 1;
      n = exp_d.size();
      chk(evt_data == exp_d[0], "R5 head before push+pop", evt_data, exp_d[0]);
      void'(exp_d.pop_front());
      void'(exp_a.pop_front());
      exp_d.push_back(pat(t - cur_leff));
      exp_a.push_back(8'(t - cur_leff - rs - 1));
      trig = 1'b1;
      evt_pop = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      evt_pop = 1'b0;
      chk(evt_cnt == 6'(n), "R7 push with pop keeps count", 128'(evt_cnt), 128'(n));
   endtask

   task automatic drain();
      while (exp_d.size() > 0) pop_check();
      chk(evt_empty == 1'b1 && evt_cnt == 6'd0, "R7 empty after drain", 128'(evt_cnt), 128'(0));
   endtask

   task automatic set_lat(input int lv);
      int k;
      bit was;
      k = edge_no + 1;
      was = (k >= rs + cur_leff + 1);
      lat_cfg = 8'(lv);
      @(negedge clk);
      chk(err_lat == was, "R4 error on latency change", 128'(err_lat), 128'(was));
      rs = k;
      cur_leff = (lv == 0) ? 256 : lv;
      @(negedge clk);
      chk(err_lat == 1'b0, "R4 error cleared by restart", 128'(err_lat), 128'(0));
   endtask

   task automatic run_case(input int stride);
      if (cur_leff >= 2) begin
         wait_until(rs + cur_leff);
         fire();
         chk(evt_empty == 1'b1, "R2 trigger before start ignored", 128'(evt_cnt), 128'(0));
      end
      wait_until(rs + cur_leff + 1);
      fire();
      for (int i = 0; i < 5; i++) begin
         repeat (stride - 1) @(negedge clk);
         fire();
      end
      chk(evt_cnt == 6'(exp_d.size()), "R7 count", 128'(evt_cnt), 128'(exp_d.size()));
      chk(err_lat == 1'b0, "R4 steady separation", 128'(err_lat), 128'(0));
      drain();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired got=%0d exp=%0d", edge_no, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      int lats[9] = '{1, 2, 3, 4, 7, 64, 200, 255, 0};
      logic [11:0] code;
      // R3 codec sweep: every address, no flip and each single flip
      for (int a = 0; a < 256; a++) begin
         for (int j = -1; j < 12; j++) begin
            code = ham_enc(8'(a));
            if (j >= 0) code = code ^ (12'(1) << j);
            chk(ham_dec(code) == 8'(a), "R3 single-bit correction", 128'(ham_dec(code)), 128'(a));
         end
      end
      repeat (3) @(negedge clk);
      rs = edge_no;
      cur_leff = 5;
      chk(evt_empty && !evt_full && evt_cnt == 6'd0, "R10 reset buffer", 128'(evt_cnt), 128'(0));
      chk(!err_lat && !err_full, "R10 reset errors", 128'({err_lat, err_full}), 128'(0));
      rst_n = 1'b1;
      run_case(1);
      for (int i = 0; i < 9; i++) begin
         set_lat(lats[i]);
         run_case(1 + (i % 3));
         if (i == 2) begin
            // R6 R9: back-to-back triggers overfill the buffer
            repeat (33) fire();
            chk(evt_cnt == 6'd32 && evt_full, "R7 full at 32", 128'(evt_cnt), 128'(32));
            chk(err_full == 1'b1, "R6 drop sets err_full", 128'(err_full), 128'(1));
            repeat (3) pop_check();
            fire_pop();
            fire_pop();
            drain();
            evt_pop = 1'b1;
            @(negedge clk);
            evt_pop = 1'b0;
            chk(evt_empty && !evt_full && evt_cnt == 6'd0, "R8 pop on empty ignored", 128'(evt_cnt), 128'(0));
            fire();
            chk(evt_cnt == 6'd1, "R8 buffer intact after empty pop", 128'(evt_cnt), 128'(1));
            drain();
         end
      end
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(!err_full && !err_lat && evt_empty, "R10 reset clears sticky error", 128'(err_full), 128'(0));
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule